// File: doc/BRIEF.md
# SPI Message Controller with Command Prepend

This block is a register-programmed SPI master. Each start command runs exactly one whole message. Software first fills a transmit byte buffer. It then chooses a message kind and a byte count, and finally writes a command word that selects one of eight devices and, for reads, a number of leading command bytes. The controller asserts that device's chip select once and clocks every byte of the message inside that single window. It writes received bytes into a receive array and raises a completion flag. The completion flag can be routed to an interrupt line through a mask.

A read message first shifts out the leading command bytes from the front of the transmit buffer. It then shifts in the requested number of data bytes while holding the data line low. The whole exchange happens without releasing chip select. The bit rate is not a free divider: a 3-bit speed code selects one entry of a fixed divider table applied to a 100 MHz system clock. The serial format is clock idle low, data launched on the falling edge and sampled on the rising edge, most significant bit first.

Top module: `spi_msg_ctrl`

## Requirements
- R1: After reset all chip selects are high, sclk is low, irq is low, and the status register (address 67) reads zero.
- R2: The speed register (address 66, bits [2:0]) selects the bit period D in system clocks. Code 0 gives 5, code 6 gives 8, code 5 gives 16, code 4 gives 32, code 3 gives 64, code 2 gives 128, and codes 1 and 7 give 256. Each bit holds sclk low for D-D/2 cycles and then high for D/2 cycles (integer division).
- R3: mosi carries each byte most significant bit first. It is valid from the start of a bit's low half until that bit's falling edge. miso is captured on the rising edge.
- R4: Writing the message register (address 64) sets the kind from bits [1:0] (1 write, 2 read, 3 duplex) and the count from bits [8:2]. A write message sends buffer bytes 0 to count-1, which software loads at addresses 0 to 63 (bits [7:0]).
- R5: A read message sends buffer bytes 0 to P-1, where P is command bits [13:8]. It then clocks count further bytes with mosi low. Each of those received bytes is stored in the receive array, read at addresses 0 to 63, starting at entry 0.
- R6: A duplex message sends buffer bytes 0 to count-1 and stores every received byte, byte i going to receive entry i.
- R7: A command write (address 65) with bits [1:0] equal to 1 starts a message on the device given by bits [4:2]. Only that device's active-low chip select goes low, and it stays low for the whole message. It falls D-D/2 cycles before the first rising edge and rises D-D/2 cycles after the last falling edge.
- R8: Status bit 0 (done) sets in the same cycle that chip select rises. irq equals done AND mask register (address 68) bit 0. Writing 16'hFFFF to the status address clears done, and any other value written there leaves it unchanged.
- R9: Status bit 1 reads 1 while a message is running. A start command issued during a message is ignored.
- R10: A start command is ignored when the kind is 0, the count is 0, or the count exceeds 64. In that case no chip select moves and done stays clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, 100 MHz assumed |
| rst_n | input | 1 | Active-low asynchronous-free synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 16 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 16 | Register read data, combinational |
| sclk | output | 1 | Serial bit clock |
| mosi | output | 1 | Serial data to devices |
| miso | input | 1 | Serial data from devices |
| cs_n | output | 8 | Active-low chip selects, one per device |
| irq | output | 1 | Masked completion interrupt |

## Verification
The embedded assertions check the following on every cycle:
- At most one chip select is low.
- The selected device never changes within a running message.
- Done is set whenever chip select releases.
- sclk toggles only when the half-period timer expires.
- Receive writes stay inside the array.

Only the bench's scenarios can show the rest:
- exact half-period lengths per speed code;
- bit order on mosi;
- the prepend-then-receive split;
- duplex capture;
- rejection of malformed or overlapping starts;
- the clear-all rule on the status register.

For these, a cycle-accurate model of the expected waveform is compared against the pins.

// File: rtl/spi_msg_pkg.sv
package spi_msg_pkg;

   typedef enum logic [1:0] {
      MK_NONE   = 2'd0,
      MK_WRITE  = 2'd1,
      MK_READ   = 2'd2,
      MK_DUPLEX = 2'd3
   } msg_kind_e;

   typedef enum logic [1:0] {
      PH_IDLE,
      PH_LOW,
      PH_HIGH,
      PH_TAIL
   } phase_e;

   localparam logic [1:0]  CMD_GO    = 2'b01;
   localparam logic [15:0] CLEAR_ALL = 16'hFFFF;
   localparam int          HALF_W    = 9;

   // bit period in system clocks for a speed code
   function automatic logic [HALF_W-1:0] code_period(input logic [2:0] code);
      case (code)
         3'd0:    return HALF_W'(5);
         3'd6:    return HALF_W'(8);
         3'd5:    return HALF_W'(16);
         3'd4:    return HALF_W'(32);
         3'd3:    return HALF_W'(64);
         3'd2:    return HALF_W'(128);
         default: return HALF_W'(256);
      endcase
   endfunction

   function automatic logic [HALF_W-1:0] low_half(input logic [2:0] code);
      logic [HALF_W-1:0] p;
      p = code_period(code);
      return p - (p >> 1);
   endfunction

   function automatic logic [HALF_W-1:0] high_half(input logic [2:0] code);
      return code_period(code) >> 1;
   endfunction

endpackage

// File: rtl/spi_half_timer.sv
module spi_half_timer #(
   parameter int CW = 9
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   output logic          expire
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (load)
         cnt_q <= len - CW'(1);
      else if (cnt_q != '0)
         cnt_q <= cnt_q - CW'(1);
   end

   assign expire = (cnt_q == '0);

   // R2: a half period is never programmed as zero cycles
   a_r2_len_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> (len != '0));

endmodule

// File: rtl/spi_byte_shifter.sv
module spi_byte_shifter #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   input  logic         sample,
   input  logic         miso,
   output logic         mosi,
   output logic [W-1:0] dout
);

   logic [W-1:0] tx_q, rx_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         tx_q <= '0;
         rx_q <= '0;
      end else begin
         if (load)
            tx_q <= din;
         else if (shift)
            tx_q <= {tx_q[W-2:0], 1'b0};
         if (sample)
            rx_q <= {rx_q[W-2:0], miso};
      end
   end

   assign mosi = tx_q[W-1];
   assign dout = rx_q;

   // R3: a new byte and a bit shift never collide
   a_r3_load_xor_shift: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift));

endmodule

// File: rtl/spi_msg_seq.sv
module spi_msg_seq
   import spi_msg_pkg::*;
#(
   parameter int DEPTH = 64,
   parameter int CNT_W = 7,
   parameter int PRE_W = 6,
   parameter int IDX_W = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              go,
   input  msg_kind_e         kind,
   input  logic [CNT_W-1:0]  count,
   input  logic [PRE_W-1:0]  prepend,
   input  logic [2:0]        speed,
   input  logic              t_expire,
   output logic              t_load,
   output logic [HALF_W-1:0] t_len,
   output logic              sclk,
   output logic              busy,
   output logic              finish,
   output logic              sh_load,
   output logic              sh_shift,
   output logic              sh_sample,
   output logic [PRE_W-1:0]  fetch_idx,
   output logic              fetch_zero,
   output logic              rx_we,
   output logic [PRE_W-1:0]  rx_idx
);

   phase_e            ph_q, ph_d;
   msg_kind_e         k_q;
   logic [IDX_W-1:0]  total_q, pre_q, byte_q, byte_nx, rx_full;
   logic [HALF_W-1:0] lo_q, hi_q;
   logic [2:0]        bit_q;
   logic              last_bit, last_byte, capture;

   assign last_bit  = (bit_q == 3'd7);
   assign last_byte = (byte_q == total_q - IDX_W'(1));
   assign capture   = (k_q == MK_DUPLEX) || ((k_q == MK_READ) && (byte_q >= pre_q));
   assign byte_nx   = byte_q + IDX_W'(1);
   assign rx_full   = (k_q == MK_READ) ? byte_q - pre_q : byte_q;
   assign rx_idx    = rx_full[PRE_W-1:0];

   always_comb begin
      if (ph_q == PH_IDLE) begin
         fetch_idx  = '0;
         fetch_zero = (kind == MK_READ) && (prepend == '0);
      end else begin
         fetch_idx  = byte_nx[PRE_W-1:0];
         fetch_zero = (k_q == MK_READ) && (byte_nx >= pre_q);
      end
   end

   always_comb begin
      ph_d      = ph_q;
      t_load    = 1'b0;
      t_len     = lo_q;
      sh_load   = 1'b0;
      sh_shift  = 1'b0;
      sh_sample = 1'b0;
      finish    = 1'b0;
      rx_we     = 1'b0;
      case (ph_q)
         PH_IDLE: if (go) begin
            ph_d    = PH_LOW;
            t_load  = 1'b1;
            t_len   = low_half(speed);
            sh_load = 1'b1;
         end
         PH_LOW: if (t_expire) begin
            ph_d      = PH_HIGH;
            t_load    = 1'b1;
            t_len     = hi_q;
            sh_sample = 1'b1;
         end
         PH_HIGH: if (t_expire) begin
            t_load = 1'b1;
            if (last_bit) begin
               rx_we = capture;
               if (last_byte) begin
                  ph_d = PH_TAIL;
               end else begin
                  ph_d    = PH_LOW;
                  sh_load = 1'b1;
               end
            end else begin
               ph_d     = PH_LOW;
               sh_shift = 1'b1;
            end
         end
         default: if (t_expire) begin
            ph_d   = PH_IDLE;
            finish = 1'b1;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph_q    <= PH_IDLE;
         k_q     <= MK_NONE;
         total_q <= '0;
         pre_q   <= '0;
         byte_q  <= '0;
         bit_q   <= '0;
         lo_q    <= '0;
         hi_q    <= '0;
      end else begin
         ph_q <= ph_d;
         if (ph_q == PH_IDLE && go) begin
            k_q     <= kind;
            pre_q   <= (kind == MK_READ) ? IDX_W'(prepend) : '0;
            total_q <= (kind == MK_READ) ? IDX_W'(count) + IDX_W'(prepend) : IDX_W'(count);
            byte_q  <= '0;
            bit_q   <= '0;
            lo_q    <= low_half(speed);
            hi_q    <= high_half(speed);
         end else if (ph_q == PH_HIGH && t_expire) begin
            if (last_bit) begin
               bit_q  <= '0;
               byte_q <= byte_nx;
            end else begin
               bit_q <= bit_q + 3'd1;
            end
         end
      end
   end

   assign sclk = (ph_q == PH_HIGH);
   assign busy = (ph_q != PH_IDLE);

   // R2: the bit clock only moves when the half-period timer runs out
   a_r2_sclk_on_expire: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sclk) |-> $past(t_expire));

   // R5: received bytes land inside the receive array
   a_r5_rx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      rx_we |-> (rx_full < IDX_W'(DEPTH)));

endmodule

// File: rtl/spi_msg_ctrl.sv
module spi_msg_ctrl
   import spi_msg_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int NUM_CS = 8,
   parameter int DW     = 16,
   parameter int AW     = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [DW-1:0]     wr_data,
   input  logic [AW-1:0]     rd_addr,
   output logic [DW-1:0]     rd_data,
   output logic              sclk,
   output logic              mosi,
   input  logic              miso,
   output logic [NUM_CS-1:0] cs_n,
   output logic              irq
);

   localparam int IDX_LOG = $clog2(DEPTH);
   localparam int CNT_W   = IDX_LOG + 1;
   localparam int DEV_W   = $clog2(NUM_CS);
   localparam int DEV_LSB = 2;
   localparam int PRE_LSB = 8;
   localparam logic [AW-1:0] A_MSG  = AW'(DEPTH);
   localparam logic [AW-1:0] A_CMD  = AW'(DEPTH + 1);
   localparam logic [AW-1:0] A_CLK  = AW'(DEPTH + 2);
   localparam logic [AW-1:0] A_STAT = AW'(DEPTH + 3);
   localparam logic [AW-1:0] A_MASK = AW'(DEPTH + 4);

   if ((1 << IDX_LOG) != DEPTH || DEPTH < 2) begin : g_bad_depth
      $error("DEPTH must be a power of two");
   end
   if (DEPTH + 5 > (1 << AW)) begin : g_bad_aw
      $error("AW too narrow for buffer plus registers");
   end
   if (PRE_LSB + IDX_LOG > DW || 2 + CNT_W > DW || DEV_LSB + DEV_W > PRE_LSB) begin : g_bad_dw
      $error("DW too narrow for register fields");
   end
   if (NUM_CS < 2) begin : g_bad_cs
      $error("NUM_CS must be at least 2");
   end

   msg_kind_e          kind_r;
   logic [CNT_W-1:0]   count_r;
   logic [2:0]         speed_r;
   logic               mask_r, done_r;
   logic [DEV_W-1:0]   dev_q;
   logic [7:0]         txbuf [DEPTH];
   logic [7:0]         rxbuf [DEPTH];

   logic               go, busy, finish, t_load, t_expire;
   logic [HALF_W-1:0]  t_len;
   logic               sh_load, sh_shift, sh_sample, fetch_zero, rx_we;
   logic [IDX_LOG-1:0] fetch_idx, rx_idx;
   logic [7:0]         tx_pick, rx_byte;

   assign go = wr_en && (wr_addr == A_CMD) && (wr_data[1:0] == CMD_GO) && !busy &&
               (kind_r != MK_NONE) && (count_r != '0) && (count_r <= CNT_W'(DEPTH));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         kind_r  <= MK_NONE;
         count_r <= '0;
         speed_r <= '0;
         mask_r  <= 1'b0;
         done_r  <= 1'b0;
         dev_q   <= '0;
      end else begin
         if (wr_en && wr_addr == A_MSG) begin
            kind_r  <= msg_kind_e'(wr_data[1:0]);
            count_r <= wr_data[2 +: CNT_W];
         end
         if (wr_en && wr_addr == A_CLK)  speed_r <= wr_data[2:0];
         if (wr_en && wr_addr == A_MASK) mask_r  <= wr_data[0];
         if (go) dev_q <= wr_data[DEV_LSB +: DEV_W];
         if (finish)
            done_r <= 1'b1;
         else if (wr_en && wr_addr == A_STAT && wr_data == CLEAR_ALL)
            done_r <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && wr_addr < AW'(DEPTH)) txbuf[wr_addr[IDX_LOG-1:0]] <= wr_data[7:0];
      if (rx_we) rxbuf[rx_idx] <= rx_byte;
   end

   assign tx_pick = fetch_zero ? 8'h00 : txbuf[fetch_idx];

   always_comb begin
      rd_data = '0;
      if (rd_addr < AW'(DEPTH)) begin
         rd_data[7:0] = rxbuf[rd_addr[IDX_LOG-1:0]];
      end else if (rd_addr == A_MSG) begin
         rd_data[1:0]       = kind_r;
         rd_data[2 +: CNT_W] = count_r;
      end else if (rd_addr == A_CLK) begin
         rd_data[2:0] = speed_r;
      end else if (rd_addr == A_STAT) begin
         rd_data[1:0] = {busy, done_r};
      end else if (rd_addr == A_MASK) begin
         rd_data[0] = mask_r;
      end
   end

   spi_half_timer #(.CW(HALF_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(t_load), .len(t_len), .expire(t_expire)
   );

   spi_byte_shifter #(.W(8)) u_shift (
      .clk(clk), .rst_n(rst_n), .load(sh_load), .din(tx_pick), .shift(sh_shift),
      .sample(sh_sample), .miso(miso), .mosi(mosi), .dout(rx_byte)
   );

   spi_msg_seq #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PRE_W(IDX_LOG)) u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .kind(kind_r), .count(count_r),
      .prepend(wr_data[PRE_LSB +: IDX_LOG]), .speed(speed_r),
      .t_expire(t_expire), .t_load(t_load), .t_len(t_len),
      .sclk(sclk), .busy(busy), .finish(finish),
      .sh_load(sh_load), .sh_shift(sh_shift), .sh_sample(sh_sample),
      .fetch_idx(fetch_idx), .fetch_zero(fetch_zero),
      .rx_we(rx_we), .rx_idx(rx_idx)
   );

   for (genvar g = 0; g < NUM_CS; g++) begin : g_cs
      assign cs_n[g] = !(busy && dev_q == DEV_W'(g));
   end

   assign irq = done_r & mask_r;

   // R7: never more than one device selected
   a_r7_single_select: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(~cs_n));

   // R9: a running message keeps its device regardless of new commands
   a_r9_select_steady: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cs_n));

   // R8: done is up in the cycle the select releases
   a_r8_done_on_release: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(&cs_n) |-> done_r);

endmodule

// File: tb/test_spi_msg_ctrl.sv
module test_spi_msg_ctrl;

   localparam int CLK_PERIOD = 10;
   localparam int A_MSG  = 64;
   localparam int A_CMD  = 65;
   localparam int A_CLK  = 66;
   localparam int A_STAT = 67;
   localparam int A_MASK = 68;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  wr_addr = '0;
   logic [15:0] wr_data = '0;
   logic [7:0]  rd_addr = '0;
   logic [15:0] rd_data;
   logic        sclk, mosi;
   logic        miso = 1'b0;
   logic [7:0]  cs_n;
   logic        irq;

   int n_chk = 0;
   int n_bad = 0;
   logic [7:0] tbuf [64];
   logic [7:0] sl   [128];
   logic [7:0] tx   [128];

   always #(CLK_PERIOD/2) clk = ~clk;

   spi_msg_ctrl i_spi_msg_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(rd_addr), .rd_data(rd_data), .sclk(sclk), .mosi(mosi), .miso(miso),
      .cs_n(cs_n), .irq(irq)
   );

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic reg_wr(input int addr, input int data);
      @(negedge clk);
      wr_en = 1'b1; wr_addr = 8'(addr); wr_data = 16'(data);
      @(posedge clk);
      #1 wr_en = 1'b0;
   endtask

   task automatic rd_reg(input int addr, output int val);
      rd_addr = 8'(addr);
      #1 val = int'(rd_data);
   endtask

   function automatic int period(input int code);
      case (code)
         0: return 5;
         6: return 8;
         5: return 16;
         4: return 32;
         3: return 64;
         2: return 128;
         default: return 256;
      endcase
   endfunction

   // one clock of the reference waveform
   task automatic step(input bit act, input int dev, input bit ex_sclk, input bit ck_mosi,
                       input bit ex_mosi, input bit miso_v, input int cyc, input int inj_at);
      int st;
      logic [7:0] ex_cs;
      @(negedge clk);
      wr_en = 1'b0;
      ex_cs = act ? ~(8'd1 << dev) : 8'hFF;
      chk(cs_n == ex_cs, "R7 chip select", cs_n, ex_cs);
      chk(sclk == ex_sclk, "R2 sclk phase", sclk, ex_sclk);
      if (ck_mosi) chk(mosi == ex_mosi, "R3 mosi bit", mosi, ex_mosi);
      miso = miso_v;
      if (cyc == inj_at) begin
         rd_reg(A_STAT, st);
         chk(st[1] == 1'b1, "R9 busy flag", st[1], 1);
         wr_en = 1'b1; wr_addr = 8'(A_CMD); wr_data = 16'(((dev + 3) % 8) << 2 | 1);
      end
   endtask

   task automatic idle(input int n);
      for (int i = 0; i < n; i++) step(1'b0, 0, 1'b0, 1'b0, 1'b0, 1'b0, -1, -2);
   endtask

   task automatic run_msg(input int kind, input int count, input int pre, input int dev,
                          input int code, input int salt, input int inj_at);
      int n, lo, hi, cyc, st;
      lo = period(code) - period(code) / 2;
      hi = period(code) / 2;
      n  = (kind == 2) ? pre + count : count;
      for (int i = 0; i < n; i++) begin
         tx[i] = (kind == 2 && i >= pre) ? 8'h00 : tbuf[i];
         sl[i] = 8'(salt ^ (i * 29) ^ 8'h3C);
      end
      reg_wr(A_CLK, code);
      reg_wr(A_MSG, (count << 2) | kind);
      reg_wr(A_CMD, (pre << 8) | (dev << 2) | 1);
      cyc = 0;
      for (int i = 0; i < n; i++) begin
         for (int k = 7; k >= 0; k--) begin
            for (int c = 0; c < lo; c++) begin
               step(1'b1, dev, 1'b0, 1'b1, tx[i][k], sl[i][k], cyc, inj_at); cyc++;
            end
            for (int c = 0; c < hi; c++) begin
               step(1'b1, dev, 1'b1, 1'b1, tx[i][k], sl[i][k], cyc, inj_at); cyc++;
            end
         end
      end
      for (int c = 0; c < lo; c++) begin
         step(1'b1, dev, 1'b0, 1'b0, 1'b0, 1'b0, cyc, inj_at); cyc++;
      end
      step(1'b0, dev, 1'b0, 1'b0, 1'b0, 1'b0, cyc, inj_at);
      rd_reg(A_STAT, st);
      chk(st[1:0] == 2'b01, "R8 done set, R9 idle", st[1:0], 1);
      if (kind == 2) begin
         for (int j = 0; j < count; j++) begin
            rd_reg(j, st);
            chk(st[7:0] == sl[pre + j], "R5 read data", st[7:0], sl[pre + j]);
         end
      end
      if (kind == 3) begin
         for (int j = 0; j < count; j++) begin
            rd_reg(j, st);
            chk(st[7:0] == sl[j], "R6 duplex data", st[7:0], sl[j]);
         end
      end
   endtask

   initial begin
      #(CLK_PERIOD * 200000);
      n_chk++; n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      int v;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      @(negedge clk);
      chk(cs_n == 8'hFF, "R1 cs idle", cs_n, 8'hFF);
      chk(sclk == 1'b0, "R1 sclk idle", sclk, 0);
      chk(irq == 1'b0, "R1 irq idle", irq, 0);
      rd_reg(A_STAT, v);
      chk(v == 0, "R1 status", v, 0);

      for (int i = 0; i < 8; i++) begin
         tbuf[i] = 8'(8'hA1 + i * 8'h13);
         reg_wr(i, tbuf[i]);
      end
      idle(3);

      // R4 write, fastest code
      run_msg(1, 3, 0, 2, 0, 8'h11, -1);
      chk(irq == 1'b0, "R8 irq masked", irq, 0);
      reg_wr(A_STAT, 16'h0001);
      rd_reg(A_STAT, v);
      chk(v[0] == 1'b1, "R8 partial write keeps done", v[0], 1);
      reg_wr(A_MASK, 1);
      @(negedge clk);
      chk(irq == 1'b1, "R8 irq unmasked", irq, 1);
      reg_wr(A_STAT, 16'hFFFF);
      @(negedge clk);
      chk(irq == 1'b0, "R8 clear-all", irq, 0);
      rd_reg(A_STAT, v);
      chk(v[0] == 1'b0, "R8 done cleared", v[0], 0);

      // R5 read with two prepend bytes, busy start injected (R9)
      run_msg(2, 3, 2, 5, 6, 8'h5A, 50);
      chk(irq == 1'b1, "R8 irq after read", irq, 1);
      reg_wr(A_STAT, 16'hFFFF);

      // R6 duplex
      run_msg(3, 4, 0, 7, 5, 8'hC3, -1);
      reg_wr(A_STAT, 16'hFFFF);

      // R5 read without prepend, R2 another code
      run_msg(2, 2, 0, 0, 4, 8'h27, -1);
      reg_wr(A_STAT, 16'hFFFF);
      run_msg(1, 1, 0, 3, 1, 8'h00, -1);
      reg_wr(A_STAT, 16'hFFFF);

      // R10 malformed starts
      reg_wr(A_MSG, (2 << 2) | 0);
      reg_wr(A_CMD, (1 << 2) | 1);
      idle(12);
      reg_wr(A_MSG, (0 << 2) | 1);
      reg_wr(A_CMD, (1 << 2) | 1);
      idle(12);
      reg_wr(A_MSG, (65 << 2) | 3);
      reg_wr(A_CMD, (1 << 2) | 1);
      idle(12);
      rd_reg(A_STAT, v);
      chk(v[1:0] == 2'b00, "R10 no message ran", v[1:0], 0);

      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule